// File: doc/BRIEF.md
# SCSI Selection Sequencer

This block runs the initiator's select command when data moves by programmed I/O. A pulse on `start` captures the target ID and whether the attention variant was ordered. The block then holds a selection request towards the target-side interface. While it waits, a cycle counter runs against a limit equal to the timeout setting times the clock-conversion factor times 8192. If the target never answers, the block reports a disconnect. If the target answers, the block drains the outgoing bytes from the controller FIFO and presents each one on a strobed output.

With attention, exactly one identify byte leaves first during the message-out phase. After that, command-descriptor bytes are sent during the command phase until the FIFO runs dry or twelve bytes have gone. Progress shows through a sequence-step code, a phase code, the interrupt-status byte and a connection flag. On either outcome a one-cycle `done` pulse goes out together with a `cmd_clear` pulse, so the surrounding command logic can raise its interrupt and flush its command ranks.

Top module: `ssq_select_seq`

## Requirements
- R1: After reset, `seq_step`, `phase`, `int_status`, `target_id` and `conn_initiator` are 0, and `sel_req`, `fifo_pop`, `byte_vld`, `done` and `cmd_clear` are low.
- R2: A `start` pulse in idle captures `target_id` from the ID input, forces `seq_step` to 0 and raises `sel_req` from the next cycle on.
- R3: Without `sel_ack`, `sel_req` stays high for exactly `tmo_reg` × `clk_conv` × 8192 cycles and pops nothing. Then `int_status` becomes 0x20, `seq_step` stays 0, `conn_initiator` becomes 0, and `done` and `cmd_clear` pulse together.
- R4: A sampled `sel_ack` ends the wait in that cycle: `sel_req` drops in the next cycle and the transfer continues.
- R5: With attention, `phase` becomes 6 (message out) and `seq_step` becomes 1. At most one byte is popped, marked by `byte_is_msg`, and none is popped when the FIFO is empty.
- R6: In the command step, `phase` is 2 (command) and `seq_step` is 3. Bytes are popped in FIFO order, one per cycle, until the FIFO is empty or 12 bytes have gone.
- R7: On success, `seq_step` becomes 4, `int_status` becomes 0x18, `conn_initiator` becomes 1, and `done` and `cmd_clear` pulse together.
- R8: `done` is high for exactly one cycle for each finished select.
- R9: A `start` pulse while a select is running is ignored; the captured target ID does not change.
- R10: A timeout product of zero ends the wait after a single request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a select command |
| with_atn | input | 1 | Select with attention (identify byte first) |
| id_sel | input | 3 | Target ID field of the bus-ID register |
| tmo_reg | input | 8 | Selection timeout setting |
| clk_conv | input | 3 | Clock-conversion factor (2 after chip reset) |
| sel_ack | input | 1 | Target responded to selection |
| fifo_empty | input | 1 | Controller FIFO holds no byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | Remove the FIFO head this cycle |
| sel_req | output | 1 | Arbitration and selection request |
| target_id | output | 3 | Captured target ID |
| phase | output | 3 | Bus phase code |
| seq_step | output | 3 | Sequence-step code |
| int_status | output | 8 | Interrupt status byte |
| conn_initiator | output | 1 | Connected as initiator |
| byte_out | output | 8 | Byte sent to the target |
| byte_vld | output | 1 | `byte_out` valid |
| byte_is_msg | output | 1 | Current byte is the identify message |
| cmd_clear | output | 1 | Clear the command ranks (pulse) |
| done | output | 1 | Select finished (pulse) |

## Verification
The select is run over a table of FIFO fills (empty, one byte, below twelve, exactly twelve, above twelve), with and without attention, and with different answer delays. This separates the identify pop from the command pops, the empty-FIFO stop from the length cap, and shows that the answer delay alone sets how long the request lasts. Directed runs with no answer check the wait length for two conversion factors and for a zero product. A second `start` in mid-run must leave the target ID unchanged.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_MSG,
      ST_CDB
   } ssq_state_t;

   localparam logic [2:0] PH_CMD     = 3'd2;
   localparam logic [2:0] PH_MSG_OUT = 3'd6;

   localparam logic [2:0] STEP_BEGIN = 3'd0;
   localparam logic [2:0] STEP_IDENT = 3'd1;
   localparam logic [2:0] STEP_CDB   = 3'd3;
   localparam logic [2:0] STEP_DONE  = 3'd4;

   localparam logic [7:0] IRQ_DISCONNECT = 8'h20;
   localparam logic [7:0] IRQ_SVC_FUNC   = 8'h18;
endpackage

// File: rtl/ssq_timer.sv
module ssq_timer #(
   parameter int TMO_W      = 8,
   parameter int CONV_W     = 3,
   parameter int SCALE_LOG2 = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic [TMO_W-1:0]  tmo_reg,
   input  logic [CONV_W-1:0] clk_conv,
   output logic              expired
);
   localparam int LW = TMO_W + CONV_W + SCALE_LOG2;

   logic [LW-1:0] limit_q;
   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limit_q <= '0;
         cnt_q   <= '0;
      end else if (load) begin
         limit_q <= LW'(LW'(tmo_reg) * LW'(clk_conv)) << SCALE_LOG2;
         cnt_q   <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + LW'(1);
      end
   end

   assign expired = run && ((cnt_q + LW'(1)) >= limit_q);
endmodule

// File: rtl/ssq_cdb_count.sv
module ssq_cdb_count #(
   parameter int MAX_CDB = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic at_max
);
   localparam int CW = $clog2(MAX_CDB + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (inc)    cnt_q <= cnt_q + CW'(1);
   end

   assign at_max = (cnt_q == CW'(MAX_CDB));
endmodule

// File: rtl/ssq_select_seq.sv
module ssq_select_seq
   import ssq_pkg::*;
#(
   parameter int TMO_W      = 8,
   parameter int CONV_W     = 3,
   parameter int SCALE_LOG2 = 13,
   parameter int MAX_CDB    = 12,
   parameter int DATA_W     = 8,
   parameter int ID_W       = 3,
   parameter bit REG_BYTE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              with_atn,
   input  logic [ID_W-1:0]   id_sel,
   input  logic [TMO_W-1:0]  tmo_reg,
   input  logic [CONV_W-1:0] clk_conv,
   input  logic              sel_ack,
   input  logic              fifo_empty,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              fifo_pop,
   output logic              sel_req,
   output logic [ID_W-1:0]   target_id,
   output logic [2:0]        phase,
   output logic [2:0]        seq_step,
   output logic [7:0]        int_status,
   output logic              conn_initiator,
   output logic [DATA_W-1:0] byte_out,
   output logic              byte_vld,
   output logic              byte_is_msg,
   output logic              cmd_clear,
   output logic              done
);
   if (MAX_CDB < 1)      begin : g_bad_cdb   $error("MAX_CDB must be at least 1"); end
   if (TMO_W < 1)        begin : g_bad_tmo   $error("TMO_W must be at least 1"); end
   if (CONV_W < 1)       begin : g_bad_conv  $error("CONV_W must be at least 1"); end
   if (SCALE_LOG2 < 0)   begin : g_bad_scale $error("SCALE_LOG2 must not be negative"); end

   ssq_state_t st_q;
   logic       atn_q;
   logic       expired;
   logic       at_max;
   logic       launch;
   logic       pop_msg;
   logic       pop_cdb;

   assign launch  = (st_q == ST_IDLE) && start;
   assign pop_msg = (st_q == ST_MSG) && !fifo_empty;
   assign pop_cdb = (st_q == ST_CDB) && !fifo_empty && !at_max;
   assign fifo_pop = pop_msg || pop_cdb;
   assign sel_req  = (st_q == ST_WAIT);

   ssq_timer #(
      .TMO_W(TMO_W), .CONV_W(CONV_W), .SCALE_LOG2(SCALE_LOG2)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .load(launch), .run(sel_req),
      .tmo_reg(tmo_reg), .clk_conv(clk_conv), .expired(expired)
   );

   ssq_cdb_count #(.MAX_CDB(MAX_CDB)) i_cdb (
      .clk(clk), .rst_n(rst_n), .clear(launch), .inc(pop_cdb), .at_max(at_max)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q           <= ST_IDLE;
         atn_q          <= 1'b0;
         target_id      <= '0;
         phase          <= '0;
         seq_step       <= '0;
         int_status     <= '0;
         conn_initiator <= 1'b0;
         cmd_clear      <= 1'b0;
         done           <= 1'b0;
      end else begin
         cmd_clear <= 1'b0;
         done      <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  target_id <= id_sel;
                  atn_q     <= with_atn;
                  seq_step  <= STEP_BEGIN;
                  st_q      <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (sel_ack) begin
                  if (atn_q) begin
                     phase    <= PH_MSG_OUT;
                     seq_step <= STEP_IDENT;
                     st_q     <= ST_MSG;
                  end else begin
                     phase    <= PH_CMD;
                     seq_step <= STEP_CDB;
                     st_q     <= ST_CDB;
                  end
               end else if (expired) begin
                  int_status     <= IRQ_DISCONNECT;
                  conn_initiator <= 1'b0;
                  cmd_clear      <= 1'b1;
                  done           <= 1'b1;
                  st_q           <= ST_IDLE;
               end
            end
            ST_MSG: begin
               phase    <= PH_CMD;
               seq_step <= STEP_CDB;
               st_q     <= ST_CDB;
            end
            ST_CDB: begin
               if (!pop_cdb) begin
                  seq_step       <= STEP_DONE;
                  int_status     <= IRQ_SVC_FUNC;
                  conn_initiator <= 1'b1;
                  cmd_clear      <= 1'b1;
                  done           <= 1'b1;
                  st_q           <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   if (REG_BYTE) begin : g_byte_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            byte_out    <= '0;
            byte_vld    <= 1'b0;
            byte_is_msg <= 1'b0;
         end else begin
            byte_out    <= fifo_data;
            byte_vld    <= fifo_pop;
            byte_is_msg <= pop_msg;
         end
      end
   end else begin : g_byte_pass
      assign byte_out    = fifo_data;
      assign byte_vld    = fifo_pop;
      assign byte_is_msg = pop_msg;
   end
endmodule

// File: rtl/ssq_select_seq_chk.sv
module ssq_select_seq_chk #(
   parameter int MAX_CDB = 12
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sel_req,
   input logic       sel_ack,
   input logic       fifo_empty,
   input logic       fifo_pop,
   input logic [2:0] phase,
   input logic [2:0] seq_step,
   input logic [7:0] int_status,
   input logic       conn_initiator,
   input logic       cmd_clear,
   input logic       done
);
   int unsigned cdb_pops;

   always_ff @(posedge clk) begin
      if (!rst_n || sel_req) cdb_pops <= 0;
      else if (fifo_pop && phase == 3'd2) cdb_pops <= cdb_pops + 1;
   end

   always_comb begin
      if (rst_n) p_cdb_cap_r6: assert (cdb_pops <= MAX_CDB);
   end

   p_pop_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> !fifo_empty);
   p_req_or_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_req, fifo_pop}));
   p_wait_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_req |-> seq_step == 3'd0);
   p_ack_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req && sel_ack) |=> !sel_req);
   p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> ((phase == 3'd6 && seq_step == 3'd1) || (phase == 3'd2 && seq_step == 3'd3)));
   p_timeout_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !conn_initiator) |-> (int_status == 8'h20 && cmd_clear && seq_step == 3'd0));
   p_success_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && conn_initiator) |-> (int_status == 8'h18 && cmd_clear && seq_step == 3'd4));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind ssq_select_seq ssq_select_seq_chk #(.MAX_CDB(MAX_CDB)) i_chk (
   .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_ack(sel_ack),
   .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .phase(phase),
   .seq_step(seq_step), .int_status(int_status),
   .conn_initiator(conn_initiator), .cmd_clear(cmd_clear), .done(done)
);

// File: tb/test_ssq_select_seq.sv
module test_ssq_select_seq;
   localparam int CLK_P = 10;
   localparam int NOACK = 1 << 30;
   localparam int NVEC  = 7;
   // {atn[21], id[20:18], unused[17:13], nbytes[12:8], ack delay[7:0]}
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 3'd3, 5'd0, 5'd7,  8'd0},
      {1'b0, 3'd5, 5'd0, 5'd6,  8'd3},
      {1'b1, 3'd1, 5'd0, 5'd20, 8'd1},
      {1'b0, 3'd7, 5'd0, 5'd12, 8'd2},
      {1'b0, 3'd2, 5'd0, 5'd0,  8'd0},
      {1'b1, 3'd4, 5'd0, 5'd0,  8'd5},
      {1'b1, 3'd0, 5'd0, 5'd1,  8'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       with_atn = 1'b0;
   logic [2:0] id_sel = '0;
   logic [7:0] tmo_reg = 8'd255;
   logic [2:0] clk_conv = 3'd2;
   logic       sel_ack = 1'b0;
   logic       fifo_empty;
   logic [7:0] fifo_data;
   logic       fifo_pop, sel_req, conn_initiator, byte_vld, byte_is_msg, cmd_clear, done;
   logic [2:0] target_id, phase, seq_step;
   logic [7:0] int_status, byte_out;

   logic [7:0] fmem [32];
   int         head = 0;
   int         fcount = 0;
   int         total = 0;
   int         bad = 0;

   assign fifo_empty = (head >= fcount);
   assign fifo_data  = (head < 32) ? fmem[head] : 8'h00;

   always #(CLK_P/2) clk = ~clk;

   ssq_select_seq i_ssq_select_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .with_atn(with_atn), .id_sel(id_sel),
      .tmo_reg(tmo_reg), .clk_conv(clk_conv), .sel_ack(sel_ack),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .sel_req(sel_req), .target_id(target_id), .phase(phase), .seq_step(seq_step),
      .int_status(int_status), .conn_initiator(conn_initiator), .byte_out(byte_out),
      .byte_vld(byte_vld), .byte_is_msg(byte_is_msg), .cmd_clear(cmd_clear), .done(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   int  r_req, r_msg, r_cdb;
   int  r_msgb;
   bit  r_order, r_clr, r_one, r_done;

   task automatic run_sel(input bit atn, input logic [2:0] id, input int nb, input int dly,
                          input logic [7:0] tmo, input logic [2:0] conv, input bit poke);
      for (int i = 0; i < 32; i++) fmem[i] = 8'hA0 + 8'(i);
      head = 0; fcount = nb;
      r_req = 0; r_msg = 0; r_cdb = 0; r_msgb = -1;
      r_order = 1'b1; r_clr = 1'b0; r_one = 1'b0; r_done = 1'b0;
      @(negedge clk);
      with_atn = atn; id_sel = id; tmo_reg = tmo; clk_conv = conv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 40000; c++) begin
         bit popped;
         if (done) begin
            r_done = 1'b1;
            r_clr  = cmd_clear;
            break;
         end
         if (sel_req) begin
            r_req++;
            sel_ack = (r_req > dly);
         end else begin
            sel_ack = 1'b0;
         end
         start = 1'b0;
         if (poke && r_req == 2) begin
            start = 1'b1; id_sel = ~id;
         end
         popped = fifo_pop;
         if (fifo_pop && byte_vld) begin
            if (byte_is_msg) begin
               r_msg++; r_msgb = int'(byte_out);
            end else begin
               if (byte_out != 8'hA0 + 8'(r_msg + r_cdb)) r_order = 1'b0;
               r_cdb++;
            end
         end
         @(posedge clk); #1;
         if (popped) head++;
         @(negedge clk);
      end
      sel_ack = 1'b0; start = 1'b0;
      @(negedge clk);
      r_one = r_done && !done;
   endtask

   initial begin
      #(CLK_P * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 outputs low", int'({sel_req, fifo_pop, byte_vld, done, cmd_clear}), 0);
      chk("R1 seq_step", int'(seq_step), 0);
      chk("R1 phase", int'(phase), 0);
      chk("R1 int_status", int'(int_status), 0);
      chk("R1 conn", int'(conn_initiator), 0);
      chk("R1 target", int'(target_id), 0);

      for (int v = 0; v < NVEC; v++) begin
         bit atn; int nb, dly, emsg, ecdb;
         atn = VEC[v][21]; nb = int'(VEC[v][12:8]); dly = int'(VEC[v][7:0]);
         emsg = (atn && nb > 0) ? 1 : 0;
         ecdb = (nb - emsg > 12) ? 12 : nb - emsg;
         run_sel(atn, VEC[v][20:18], nb, dly, 8'd255, 3'd2, 1'b0);
         chk("R4 request cycles", r_req, dly + 1);
         chk("R2 target id", int'(target_id), int'(VEC[v][20:18]));
         chk("R5 identify pops", r_msg, emsg);
         if (emsg == 1) chk("R5 identify byte", r_msgb, 'hA0);
         chk("R6 cdb pops", r_cdb, ecdb);
         chk("R6 cdb order", int'(r_order), 1);
         chk("R6 phase", int'(phase), 2);
         chk("R7 seq_step", int'(seq_step), 4);
         chk("R7 int_status", int'(int_status), 'h18);
         chk("R7 conn", int'(conn_initiator), 1);
         chk("R7 cmd_clear", int'(r_clr), 1);
         chk("R8 done one cycle", int'(r_one), 1);
      end

      // R3 timeout, factor 1
      run_sel(1'b1, 3'd2, 4, NOACK, 8'd1, 3'd1, 1'b0);
      chk("R3 wait cycles x1", r_req, 8192);
      chk("R3 no pops", r_msg + r_cdb, 0);
      chk("R3 int_status", int'(int_status), 'h20);
      chk("R3 seq_step", int'(seq_step), 0);
      chk("R3 conn", int'(conn_initiator), 0);
      chk("R3 cmd_clear", int'(r_clr), 1);
      chk("R8 done one cycle", int'(r_one), 1);

      // R3 timeout with the post-reset conversion factor
      run_sel(1'b0, 3'd6, 2, NOACK, 8'd1, 3'd2, 1'b0);
      chk("R3 wait cycles x2", r_req, 16384);
      chk("R3 int_status x2", int'(int_status), 'h20);

      // R10 zero period
      run_sel(1'b0, 3'd1, 2, NOACK, 8'd0, 3'd2, 1'b0);
      chk("R10 wait cycles", r_req, 1);
      chk("R10 int_status", int'(int_status), 'h20);

      // R4 answer well inside the period
      run_sel(1'b0, 3'd3, 3, 500, 8'd1, 3'd1, 1'b0);
      chk("R4 early answer cycles", r_req, 501);
      chk("R4 early answer result", int'(int_status), 'h18);
      chk("R4 early answer pops", r_cdb, 3);

      // R9 start while busy
      run_sel(1'b1, 3'd6, 3, 6, 8'd255, 3'd2, 1'b1);
      chk("R9 target kept", int'(target_id), 6);
      chk("R9 request cycles", r_req, 7);
      chk("R9 cdb pops", r_cdb, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule